// File: doc/BRIEF.md
# Flash Programming Mode Controller

This block models the parallel programming port of a small on-chip code flash. An external programmer drives an address, a data byte, a three-bit selector, an enable level, a store-enable strobe and an active-low program pulse. The block decodes these levels into one of seven operations: program a code byte, verify a code byte, set one of three protection bits, erase the whole array, or read the fixed identification bytes.

Programming is self-timed. The end of the program pulse starts a write that lasts a fixed number of clock cycles. During that time `ready_o` is low, and a verify read of the byte being written returns its bit 7 inverted. Erase is accepted only after the pulse has been held low long enough. The erase then sweeps every location back to FFh, one location per cycle, and clears the protection bits. The storage is a plain register array. All durations are parameters counted in clock cycles, so a simulation can run with short timings.

State machine: `S_IDLE` (waiting), `S_WRITE` (timed byte or protection-bit write), `S_EHOLD` (measuring the erase pulse), `S_ERUN` (erase sweep), `S_EREL` (waiting for the pulse to be released after the sweep). The transitions are:
- `S_IDLE`→`S_WRITE` when an accepted pulse ends.
- `S_WRITE`→`S_IDLE` when the write timer expires.
- `S_IDLE`→`S_EHOLD` when the pulse is low in erase mode.
- `S_EHOLD`→`S_IDLE` when the pulse is released early or the mode changes.
- `S_EHOLD`→`S_ERUN` when the hold time is reached.
- `S_ERUN`→`S_EREL` after the last address.
- `S_EREL`→`S_IDLE` when the pulse is high.

Top module: `flash_prog_ctrl`

## Requirements
- R1: With `store_en_n_i`=0, the operation is chosen by `enable_i` and `sel_i`. With `enable_i`=1: 011 programs a code byte, 111 sets protection bit 0, 100 sets bit 1, 010 sets bit 2, and 000 erases. With `enable_i`=0: 011 verifies a code byte and 000 reads the identification bytes.
- R2: The rising edge of `pulse_n_i`, sampled in `S_IDLE`, starts an accepted write. `ready_o` is low for exactly WRITE_CYC cycles starting the next cycle. The byte is stored when `ready_o` returns high. A pulse that ends while busy is ignored.
- R3: While a code write is busy, verifying its address returns the written byte with bit 7 inverted. After completion, the true byte is returned.
- R4: When `pulse_n_i` stays low in erase mode for ERASE_CYC sampled cycles, the block sets every byte to FFh, one per cycle, with `ready_o` low for 2^ADDR_W cycles. A shorter hold does nothing.
- R5: A code write to a byte that is not FFh is ignored: no busy period and no change. After an erase, the byte can be programmed again.
- R6: Identification reads return 1Eh at 030h, 51h at 031h, SIG_LAST (default FFh) at 032h, and FFh at any other address.
- R7: With `lock_o[0]` set, code writes are ignored: no busy period and no change.
- R8: With `lock_o[1]` set, code verify returns FFh. Identification reads still work.
- R9: Protection-bit writes take a WRITE_CYC busy period and then set the selected bit of `lock_o`. The bits are cleared only by a completed erase.
- R10: After reset, `ready_o`=1, `lock_o`=000 and every byte reads FFh.
- R11: Any selector pattern not listed in R1, or `store_en_n_i`=1, has no effect. Reads in those cases return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to the shipped (erased, unlocked) state |
| store_en_n_i | input | 1 | Store-enable strobe, must be low for any operation |
| enable_i | input | 1 | 1 selects write-type operations, 0 selects reads |
| sel_i | input | 3 | Operation selector |
| pulse_n_i | input | 1 | Active-low program pulse |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Data byte to program |
| dout_o | output | 8 | Read data |
| ready_o | output | 1 | High when idle, low during a timed write or erase |
| lock_o | output | 3 | Protection bits 0..2 |

## Verification
Two functions can overlap in the same cycle: a verify read of the address being programmed, and the write that is still in flight. The bench switches to verify mode in the first busy cycle and compares the value returned against the written byte with bit 7 inverted. After `ready_o` rises, it compares against the true byte. The bench also ends a second program pulse while the first write is busy, and checks both that the busy time is unchanged and that the second address is still blank.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WCODE,
        CMD_RCODE,
        CMD_LOCK0,
        CMD_LOCK1,
        CMD_LOCK2,
        CMD_ERASE,
        CMD_RSIG
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_EHOLD,
        S_ERUN,
        S_EREL
    } state_e;

    localparam logic [2:0] SEL_CODE  = 3'b011;
    localparam logic [2:0] SEL_LOCK0 = 3'b111;
    localparam logic [2:0] SEL_LOCK1 = 3'b100;
    localparam logic [2:0] SEL_LOCK2 = 3'b010;
    localparam logic [2:0] SEL_ERASE = 3'b000;

    localparam logic [7:0] ID_BYTE0 = 8'h1E;
    localparam logic [7:0] ID_BYTE1 = 8'h51;
    localparam logic [7:0] BLANK    = 8'hFF;

endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
    import flash_prog_pkg::*;
(
    input  logic       store_en_n_i,
    input  logic       enable_i,
    input  logic [2:0] sel_i,
    output cmd_e       cmd_o
);

    always_comb begin
        cmd_o = CMD_NONE;
        if (!store_en_n_i) begin
            if (enable_i) begin
                unique case (sel_i)
                    SEL_CODE:  cmd_o = CMD_WCODE;
                    SEL_LOCK0: cmd_o = CMD_LOCK0;
                    SEL_LOCK1: cmd_o = CMD_LOCK1;
                    SEL_LOCK2: cmd_o = CMD_LOCK2;
                    SEL_ERASE: cmd_o = CMD_ERASE;
                    default:   cmd_o = CMD_NONE;
                endcase
            end else begin
                unique case (sel_i)
                    SEL_CODE:  cmd_o = CMD_RCODE;
                    SEL_ERASE: cmd_o = CMD_RSIG;
                    default:   cmd_o = CMD_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 48000,
    parameter int ERASE_CYC = 240000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_i,
    input  logic              pulse_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    input  logic [7:0]        cur_byte_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              busy_o,
    output logic              poll_act_o,
    output logic [ADDR_W-1:0] poll_addr_o,
    output logic [7:0]        poll_data_o,
    output logic [2:0]        lock_o
);

    localparam int LIM   = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0]  W_LAST = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0]  E_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [ADDR_W-1:0] A_LAST = '1;

    state_e            st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] sweep;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    cmd_e              pend_cmd;
    logic              pulse_q;
    logic [2:0]        lock_q;
    logic              rise, write_ok, lock_req, accept;

    assign rise     = pulse_n_i & ~pulse_q;
    assign write_ok = (cmd_i == CMD_WCODE) && !lock_q[0] && (cur_byte_i == BLANK);
    assign lock_req = (cmd_i == CMD_LOCK0) || (cmd_i == CMD_LOCK1) || (cmd_i == CMD_LOCK2);
    assign accept   = rise && (write_ok || lock_req);

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (accept) st_nx = S_WRITE;
                     else if (!pulse_n_i && cmd_i == CMD_ERASE) st_nx = S_EHOLD;
            S_WRITE: if (cnt == W_LAST) st_nx = S_IDLE;
            S_EHOLD: if (pulse_n_i || cmd_i != CMD_ERASE) st_nx = S_IDLE;
                     else if (cnt == E_LAST) st_nx = S_ERUN;
            S_ERUN:  if (sweep == A_LAST) st_nx = S_EREL;
            S_EREL:  if (pulse_n_i) st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sweep     <= '0;
            pend_addr <= '0;
            pend_data <= BLANK;
            pend_cmd  <= CMD_NONE;
            pulse_q   <= 1'b1;
            lock_q    <= 3'b000;
        end else begin
            pulse_q <= pulse_n_i;
            unique case (st)
                S_IDLE: begin
                    if (accept) begin
                        cnt       <= '0;
                        pend_addr <= addr_i;
                        pend_data <= din_i;
                        pend_cmd  <= cmd_i;
                    end else begin
                        cnt <= CNT_W'(1);
                    end
                    sweep <= '0;
                end
                S_WRITE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == W_LAST) begin
                        unique case (pend_cmd)
                            CMD_LOCK0: lock_q[0] <= 1'b1;
                            CMD_LOCK1: lock_q[1] <= 1'b1;
                            CMD_LOCK2: lock_q[2] <= 1'b1;
                            default:   ;
                        endcase
                    end
                end
                S_EHOLD: cnt <= cnt + 1'b1;
                S_ERUN: begin
                    sweep <= sweep + 1'b1;
                    if (sweep == A_LAST) lock_q <= 3'b000;
                end
                S_EREL: ;
            endcase
        end
    end

    always_comb begin
        busy_o      = (st == S_WRITE) || (st == S_ERUN);
        poll_act_o  = (st == S_WRITE) && (pend_cmd == CMD_WCODE);
        poll_addr_o = pend_addr;
        poll_data_o = {~pend_data[7], pend_data[6:0]};
        mem_we_o    = (st == S_ERUN) || (poll_act_o && cnt == W_LAST);
        mem_waddr_o = (st == S_ERUN) ? sweep : pend_addr;
        mem_wdata_o = (st == S_ERUN) ? BLANK : pend_data;
        lock_o      = lock_q;
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WRITE && cnt != W_LAST) |=> (st == S_WRITE)); // R2
    AST_ERUN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && st == S_ERUN && $past(st) != S_ERUN) |-> ($past(st) == S_EHOLD)); // R4
    AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && st == S_WRITE) |-> !lock_q[0]); // R7
    AST_LOCK_CLEAR_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (|($past(lock_q) & ~lock_q))) |-> ($past(st) == S_ERUN)); // R9

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
    import flash_prog_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] SIG_LAST = 8'hFF
) (
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        mem_byte_i,
    input  logic              poll_act_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic [7:0]        poll_data_i,
    input  logic              verify_block_i,
    output logic [7:0]        dout_o
);

    localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(8'h31);
    localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(8'h32);

    always_comb begin
        dout_o = BLANK;
        if (cmd_i == CMD_RCODE) begin
            if (verify_block_i)                           dout_o = BLANK;
            else if (poll_act_i && addr_i == poll_addr_i) dout_o = poll_data_i;
            else                                          dout_o = mem_byte_i;
        end else if (cmd_i == CMD_RSIG) begin
            if (addr_i == SIG_A0)      dout_o = ID_BYTE0;
            else if (addr_i == SIG_A1) dout_o = ID_BYTE1;
            else if (addr_i == SIG_A2) dout_o = SIG_LAST;
        end
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         WRITE_CYC = 48000,
    parameter int         ERASE_CYC = 240000,
    parameter logic [7:0] SIG_LAST  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en_n_i,
    input  logic              enable_i,
    input  logic [2:0]        sel_i,
    input  logic              pulse_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    output logic [7:0]        dout_o,
    output logic              ready_o,
    output logic [2:0]        lock_o
);

    localparam int DEPTH = 1 << ADDR_W;

    cmd_e              cmd;
    logic              mem_we, busy, poll_act;
    logic [ADDR_W-1:0] mem_waddr, poll_addr;
    logic [7:0]        mem_wdata, poll_data, cur_byte;
    logic [7:0]        mem [DEPTH];

    flash_mode_dec u_dec (
        .store_en_n_i (store_en_n_i),
        .enable_i     (enable_i),
        .sel_i        (sel_i),
        .cmd_o        (cmd)
    );

    flash_prog_seq #(
        .ADDR_W    (ADDR_W),
        .WRITE_CYC (WRITE_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .pulse_n_i   (pulse_n_i),
        .addr_i      (addr_i),
        .din_i       (din_i),
        .cur_byte_i  (cur_byte),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata),
        .busy_o      (busy),
        .poll_act_o  (poll_act),
        .poll_addr_o (poll_addr),
        .poll_data_o (poll_data),
        .lock_o      (lock_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
        end else if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end

    assign cur_byte = mem[addr_i];
    assign ready_o  = ~busy;

    flash_rd_path #(
        .ADDR_W   (ADDR_W),
        .SIG_LAST (SIG_LAST)
    ) u_rd (
        .cmd_i          (cmd),
        .addr_i         (addr_i),
        .mem_byte_i     (cur_byte),
        .poll_act_i     (poll_act),
        .poll_addr_i    (poll_addr),
        .poll_data_i    (poll_data),
        .verify_block_i (lock_o[1]),
        .dout_o         (dout_o)
    );

    AST_VERIFY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_en_n_i && !enable_i && sel_i == SEL_CODE && lock_o[1]) |-> (dout_o == BLANK)); // R8
    AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_en_n_i && !enable_i && sel_i == SEL_ERASE && addr_i == ADDR_W'(8'h30))
        |-> (dout_o == ID_BYTE0)); // R6
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> !mem_we); // R2

endmodule

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int WC    = 20;
    localparam int EC    = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          store_en_n = 1'b0;
    logic          enable = 1'b0;
    logic [2:0]    sel = 3'b011;
    logic          pulse_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          ready;
    logic [2:0]    lock;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .SIG_LAST(8'hFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .store_en_n_i(store_en_n), .enable_i(enable),
        .sel_i(sel), .pulse_n_i(pulse_n), .addr_i(addr), .din_i(din),
        .dout_o(dout), .ready_o(ready), .lock_o(lock)
    );

    function automatic logic [7:0] poll_of(logic [7:0] d);
        return {~d[7], d[6:0]};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] s, logic [AW-1:0] a, output logic [7:0] v);
        enable = 1'b0; sel = s; addr = a;
        @(negedge clk);
        v = dout;
    endtask

    task automatic op(logic [2:0] s, logic [AW-1:0] a, logic [7:0] d,
                      output int busy, output logic [7:0] pv);
        enable = 1'b1; sel = s; addr = a; din = d;
        @(negedge clk); pulse_n = 1'b0;
        @(negedge clk); pulse_n = 1'b1;
        @(negedge clk);
        busy = ready ? 0 : 1;
        enable = 1'b0; sel = 3'b011;
        pv = 8'h00;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (i == 0) pv = dout;
            if (ready) break;
            busy++;
        end
    endtask

    task automatic erase(int hold, output int busy);
        enable = 1'b1; sel = 3'b000;
        @(negedge clk); pulse_n = 1'b0;
        busy = 0;
        for (int i = 0; i < hold + DEPTH + 40; i++) begin
            @(negedge clk);
            if (!ready) busy++;
            if (i == hold - 1) pulse_n = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int b;
        logic [7:0] v, pv, d;
        logic [AW-1:0] a;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(ready == 1'b1, "R10 ready", ready, 1);
        chk(lock == 3'b000, "R10 lock", lock, 0);
        rd(3'b011, 8'h05, v); chk(v == 8'hFF, "R10 blank", v, 8'hFF);

        // R6 identification bytes
        rd(3'b000, 8'h30, v); chk(v == 8'h1E, "R6 id0", v, 8'h1E);
        rd(3'b000, 8'h31, v); chk(v == 8'h51, "R6 id1", v, 8'h51);
        rd(3'b000, 8'h32, v); chk(v == 8'hFF, "R6 id2", v, 8'hFF);
        rd(3'b000, 8'h33, v); chk(v == 8'hFF, "R6 other", v, 8'hFF);

        // R1 R2 R3 directed write
        op(3'b011, 8'h10, 8'h35, b, pv);
        chk(b == WC, "R2 busy length", b, WC);
        chk(pv == poll_of(8'h35), "R3 poll", pv, poll_of(8'h35));
        rd(3'b011, 8'h10, v); chk(v == 8'h35, "R1 R3 stored", v, 8'h35);
        model[8'h10] = 8'h35;

        // R5 non-blank rewrite ignored
        op(3'b011, 8'h10, 8'h00, b, pv);
        chk(b == 0, "R5 no busy", b, 0);
        rd(3'b011, 8'h10, v); chk(v == 8'h35, "R5 unchanged", v, 8'h35);

        // R11 undefined selector and strobe high
        op(3'b101, 8'h11, 8'hC3, b, pv);
        chk(b == 0, "R11 no busy", b, 0);
        rd(3'b011, 8'h11, v); chk(v == 8'hFF, "R11 unchanged", v, 8'hFF);
        rd(3'b110, 8'h10, v); chk(v == 8'hFF, "R11 read other", v, 8'hFF);
        store_en_n = 1'b1;
        rd(3'b011, 8'h10, v); chk(v == 8'hFF, "R11 strobe high read", v, 8'hFF);
        op(3'b011, 8'h12, 8'h44, b, pv);
        chk(b == 0, "R11 strobe high write", b, 0);
        store_en_n = 1'b0;
        rd(3'b011, 8'h12, v); chk(v == 8'hFF, "R11 strobe high unchanged", v, 8'hFF);

        // R2 pulse ending while busy is ignored
        enable = 1'b1; sel = 3'b011; addr = 8'h20; din = 8'h81;
        @(negedge clk); pulse_n = 1'b0;
        @(negedge clk); pulse_n = 1'b1;
        b = 0;
        @(negedge clk); if (!ready) b++;
        addr = 8'h21; din = 8'h02; pulse_n = 1'b0;
        @(negedge clk); if (!ready) b++;
        pulse_n = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ready) break;
            b++;
        end
        chk(b == WC, "R2 busy with second pulse", b, WC);
        rd(3'b011, 8'h20, v); chk(v == 8'h81, "R2 first stored", v, 8'h81);
        rd(3'b011, 8'h21, v); chk(v == 8'hFF, "R2 second ignored", v, 8'hFF);
        model[8'h20] = 8'h81;

        // random writes with collisions
        for (int n = 0; n < 40; n++) begin
            a = AW'($urandom % 40);
            d = 8'($urandom);
            op(3'b011, a, d, b, pv);
            if (model[a] == 8'hFF) begin
                chk(b == WC, "R2 random busy", b, WC);
                chk(pv == poll_of(d), "R3 random poll", pv, poll_of(d));
                model[a] = d;
            end else begin
                chk(b == 0, "R5 random reject", b, 0);
            end
            rd(3'b011, a, v); chk(v == model[a], "R1 random readback", v, model[a]);
        end

        // R9 R7 protection bit 0
        op(3'b111, 8'h00, 8'h00, b, pv);
        chk(b == WC, "R9 lock busy", b, WC);
        chk(lock == 3'b001, "R9 lock0 set", lock, 1);
        op(3'b011, 8'h80, 8'h12, b, pv);
        chk(b == 0, "R7 write blocked", b, 0);
        rd(3'b011, 8'h80, v); chk(v == 8'hFF, "R7 unchanged", v, 8'hFF);
        rd(3'b011, 8'h10, v); chk(v == model[8'h10], "R8 verify open", v, model[8'h10]);

        // R8 protection bit 1
        op(3'b100, 8'h00, 8'h00, b, pv);
        chk(lock == 3'b011, "R9 lock1 set", lock, 3);
        rd(3'b011, 8'h10, v); chk(v == 8'hFF, "R8 verify blocked", v, 8'hFF);
        rd(3'b000, 8'h30, v); chk(v == 8'h1E, "R8 id still readable", v, 8'h1E);

        // R9 protection bit 2
        op(3'b010, 8'h00, 8'h00, b, pv);
        chk(lock == 3'b111, "R9 lock2 set", lock, 7);

        // R4 short hold does nothing
        erase(EC / 2, b);
        chk(b == 0, "R4 short hold", b, 0);
        chk(lock == 3'b111, "R9 kept after short hold", lock, 7);

        // R4 full erase
        erase(EC + 5, b);
        chk(b == DEPTH, "R4 sweep length", b, DEPTH);
        chk(lock == 3'b000, "R9 cleared by erase", lock, 0);
        rd(3'b011, 8'h10, v); chk(v == 8'hFF, "R4 erased 10", v, 8'hFF);
        rd(3'b011, 8'h20, v); chk(v == 8'hFF, "R4 erased 20", v, 8'hFF);
        rd(3'b011, 8'hFF, v); chk(v == 8'hFF, "R4 erased top", v, 8'hFF);

        // R5 reprogram after erase
        op(3'b011, 8'h10, 8'h12, b, pv);
        chk(b == WC, "R5 reprogram busy", b, WC);
        rd(3'b011, 8'h10, v); chk(v == 8'h12, "R5 reprogrammed", v, 8'h12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule